// File: doc/BRIEF.md
# Asynchronous Static RAM Controller with Byte Lanes

This block connects a synchronous host to an external asynchronous static RAM of 1M words by 16 bits. The host issues one request at a time through a valid/ready handshake. Each request carries a read/write flag, a 20-bit word address, 16 bits of write data and a 2-bit lane mask. Read data comes back with a one-cycle valid pulse. On the memory side the controller drives an active-low chip enable, an active-high second select, output enable, write enable, one strobe per byte lane and the address. The data bus is a split pair: a driven value, its output-enable, and the sampled input.

The length of every access phase is derived at elaboration from the clock period and the memory's nanosecond minimums, each rounded up to whole cycles. A write has three phases: a setup cycle with address, strobes and data already valid, the write-enable pulse, and a recovery phase. During a write, output enable is held high. A read holds output enable low for the full access time and then captures the bus. A read is followed by a turnaround in which the memory is deselected and the bus is left undriven.

With the default 5 ns clock and the faster grade's figures, the phases come to 1 setup cycle, a 7-cycle pulse, 1 recovery cycle, a 9-cycle read access and a 4-cycle turnaround.

Top module: `sram_ctl`

## Requirements
- R1: While in reset and while idle, the memory is deselected: chip enable high, second select low, write enable high, output enable high, both byte strobes high and the data bus not driven. The host ready output is high.
- R2: Ready falls at the clock edge that accepts a request. It stays low until the last phase ends: 9 cycles for a write and 13 cycles for a read (9 access plus 4 turnaround) at default parameters.
- R3: Write enable is low only while chip enable is low, the second select is high, output enable is high and the bus is driven. At default parameters each pulse lasts exactly 7 consecutive cycles and follows at least one selected cycle with write enable high.
- R4: While the memory stays selected, the address and both strobes do not change. While the bus is driven, the write data does not change.
- R5: Mask bit 0 enables the lower strobe, which covers data bits 7:0. Mask bit 1 enables the upper strobe, which covers bits 15:8. A write changes only the enabled lanes. A write with mask 00 keeps both strobes high and leaves the memory unchanged.
- R6: A read holds output enable low and write enable high for exactly 9 cycles at default parameters. The bus is sampled at the final edge of that phase and returned on rsp_rdata with rsp_valid high for exactly one cycle.
- R7: In returned read data, any lane whose mask bit is 0 reads as zero, whatever the bus carries there.
- R8: The data bus is never driven while output enable is low, nor in the cycle right after output enable was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle, accepts request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address |
| req_wdata | input | 16 | Write data |
| req_lanes | input | 2 | Lane mask, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| rsp_valid | output | 1 | One-cycle read data valid |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_cs2 | output | 1 | Second select, active high |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_lb_n | output | 1 | Lower lane strobe, active low |
| mem_ub_n | output | 1 | Upper lane strobe, active low |
| mem_addr | output | 20 | Memory address |
| mem_dq_o | output | 16 | Data driven to memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_o |
| mem_dq_i | input | 16 | Data sampled from memory |

## Verification
The bench targets partial-lane merging. It writes single lanes onto a known word and reads back with each mask. A controller that steered strobes wrongly, or failed to zero unrequested lanes, returns the bench's filler byte or a corrupted word. Mask-00 writes must leave memory untouched.

Back-to-back traffic with the valid held high checks two things. Any drive during or right after output enable flags contention. A shortened pulse or read phase shows up in the per-phase cycle counts and busy lengths.

Address and data must stay still across each selected window, so a late latch of the request shows up as a mid-cycle address change.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    localparam int ADDR_W = 20;
    localparam int DATA_W = 16;
    localparam int LANES  = 2;
    localparam int LANE_W = DATA_W / LANES;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_WSET  = 3'd1,
        ST_WPUL  = 3'd2,
        ST_WREC  = 3'd3,
        ST_RACC  = 3'd4,
        ST_RTURN = 3'd5
    } phase_e;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [LANES-1:0]  lanes;
    } req_t;

    function automatic int cdiv(input int t_ns, input int clk_ns);
        return (t_ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
module sram_ctl_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          done
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/sram_ctl_seq.sv
module sram_ctl_seq
    import sram_ctl_pkg::*;
#(
    parameter int SET_CYC = 1,
    parameter int PW_CYC  = 7,
    parameter int REC_CYC = 1,
    parameter int RD_CYC  = 9,
    parameter int TA_CYC  = 4
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   req_valid,
    input  logic   req_write,
    output logic   req_ready,
    output logic   accept,
    output phase_e phase_d,
    output logic   capture
);
    localparam int MAXC = imax(imax(imax(SET_CYC, PW_CYC), imax(REC_CYC, RD_CYC)), TA_CYC);
    localparam int CW   = $clog2(MAXC + 1);

    phase_e        phase_q;
    logic          done;
    logic          load;
    logic [CW-1:0] load_val;

    function automatic logic [CW-1:0] len_m1(input phase_e p);
        case (p)
            ST_WSET:  return CW'(SET_CYC - 1);
            ST_WPUL:  return CW'(PW_CYC - 1);
            ST_WREC:  return CW'(REC_CYC - 1);
            ST_RACC:  return CW'(RD_CYC - 1);
            ST_RTURN: return CW'(TA_CYC - 1);
            default:  return '0;
        endcase
    endfunction

    always_comb begin
        phase_d = phase_q;
        case (phase_q)
            ST_IDLE:  if (req_valid) phase_d = req_write ? ST_WSET : ST_RACC;
            ST_WSET:  if (done) phase_d = ST_WPUL;
            ST_WPUL:  if (done) phase_d = ST_WREC;
            ST_WREC:  if (done) phase_d = ST_IDLE;
            ST_RACC:  if (done) phase_d = ST_RTURN;
            ST_RTURN: if (done) phase_d = ST_IDLE;
            default:  phase_d = ST_IDLE;
        endcase
    end

    assign load     = (phase_d != phase_q);
    assign load_val = len_m1(phase_d);
    assign req_ready = (phase_q == ST_IDLE);
    assign accept    = req_ready && req_valid;
    assign capture   = (phase_q == ST_RACC) && done;

    always_ff @(posedge clk) begin
        if (rst) phase_q <= ST_IDLE;
        else     phase_q <= phase_d;
    end

    sram_ctl_timer #(.CW(CW)) i_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (load_val),
        .done     (done)
    );

    // R3: the write pulse phase is always entered from setup
    p_pulse_after_setup_r3: assert property (@(posedge clk) disable iff (rst)
        (phase_q == ST_WPUL && $past(phase_q) != ST_WPUL) |-> $past(phase_q) == ST_WSET);
endmodule

// File: rtl/sram_ctl_lanes.sv
module sram_ctl_lanes
    import sram_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  req_t              req_in,
    input  phase_e            phase_d,
    input  logic              capture,
    input  logic [DATA_W-1:0] dq_i,
    output logic              ce_n,
    output logic              cs2,
    output logic              oe_n,
    output logic              we_n,
    output logic [LANES-1:0]  strobe_n,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] dq_o,
    output logic              dq_oe,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);
    req_t              held, cur;
    logic              sel_d, wdrive_d;
    logic [DATA_W-1:0] rd_masked;

    assign cur      = accept ? req_in : held;
    assign sel_d    = (phase_d == ST_WSET) || (phase_d == ST_WPUL) ||
                      (phase_d == ST_WREC) || (phase_d == ST_RACC);
    assign wdrive_d = (phase_d == ST_WSET) || (phase_d == ST_WPUL) ||
                      (phase_d == ST_WREC);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign rd_masked[g*LANE_W +: LANE_W] =
            held.lanes[g] ? dq_i[g*LANE_W +: LANE_W] : '0;

        always_ff @(posedge clk) begin
            if (rst) strobe_n[g] <= 1'b1;
            else     strobe_n[g] <= !(sel_d && cur.lanes[g]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held      <= '0;
            ce_n      <= 1'b1;
            cs2       <= 1'b0;
            oe_n      <= 1'b1;
            we_n      <= 1'b1;
            addr      <= '0;
            dq_o      <= '0;
            dq_oe     <= 1'b0;
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            held      <= cur;
            ce_n      <= !sel_d;
            cs2       <= sel_d;
            oe_n      <= (phase_d != ST_RACC);
            we_n      <= (phase_d != ST_WPUL);
            addr      <= cur.addr;
            dq_o      <= cur.wdata;
            dq_oe     <= wdrive_d;
            rsp_valid <= capture;
            if (capture) rsp_rdata <= rd_masked;
        end
    end

    // R5: a strobe is only ever active while the chip is selected
    p_strobe_selected_r5: assert property (@(posedge clk) disable iff (rst)
        (strobe_n != {LANES{1'b1}}) |-> (!ce_n && cs2));
endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int CLK_NS   = 5,
    parameter int T_WC_NS  = 45,
    parameter int T_PWE_NS = 35,
    parameter int T_AW_NS  = 35,
    parameter int T_SD_NS  = 28,
    parameter int T_AA_NS  = 45,
    parameter int T_HZ_NS  = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_lanes,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              mem_ce_n,
    output logic              mem_cs2,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic              mem_lb_n,
    output logic              mem_ub_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_i
);
    localparam int SET_CYC = 1;
    localparam int PW_CYC  = cdiv(imax(imax(T_PWE_NS, T_SD_NS), T_AW_NS), CLK_NS);
    localparam int REC_CYC = imax(1, cdiv(T_WC_NS, CLK_NS) - SET_CYC - PW_CYC);
    localparam int RD_CYC  = imax(1, cdiv(T_AA_NS, CLK_NS));
    localparam int TA_CYC  = imax(1, cdiv(T_HZ_NS, CLK_NS));

    logic             accept, capture;
    phase_e           phase_d;
    req_t             req_in;
    logic [LANES-1:0] strobe_n;

    assign req_in   = '{wr: req_write, addr: req_addr, wdata: req_wdata, lanes: req_lanes};
    assign mem_lb_n = strobe_n[0];
    assign mem_ub_n = strobe_n[1];

    sram_ctl_seq #(
        .SET_CYC (SET_CYC),
        .PW_CYC  (PW_CYC),
        .REC_CYC (REC_CYC),
        .RD_CYC  (RD_CYC),
        .TA_CYC  (TA_CYC)
    ) i_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_ready (req_ready),
        .accept    (accept),
        .phase_d   (phase_d),
        .capture   (capture)
    );

    sram_ctl_lanes i_lanes (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .req_in    (req_in),
        .phase_d   (phase_d),
        .capture   (capture),
        .dq_i      (mem_dq_i),
        .ce_n      (mem_ce_n),
        .cs2       (mem_cs2),
        .oe_n      (mem_oe_n),
        .we_n      (mem_we_n),
        .strobe_n  (strobe_n),
        .addr      (mem_addr),
        .dq_o      (mem_dq_o),
        .dq_oe     (mem_dq_oe),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    p_idle_deselect_r1: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (mem_ce_n && !mem_cs2 && mem_we_n && mem_oe_n && !mem_dq_oe));

    p_we_selected_r3: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> (!mem_ce_n && mem_cs2 && mem_oe_n && mem_dq_oe));

    p_addr_stable_r4: assert property (@(posedge clk) disable iff (rst)
        (!mem_ce_n && $past(!mem_ce_n)) |->
            ($stable(mem_addr) && $stable(mem_lb_n) && $stable(mem_ub_n)));

    p_wdata_stable_r4: assert property (@(posedge clk) disable iff (rst)
        (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_o));

    p_rsp_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    p_read_we_high_r6: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> mem_we_n);

    p_no_drive_oe_r8: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> !mem_dq_oe);

    p_turnaround_r8: assert property (@(posedge clk) disable iff (rst)
        $past(!mem_oe_n) |-> !mem_dq_oe);
endmodule

// File: tb/test_sram_ctl.sv
module test_sram_ctl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [19:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_lanes = '0;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic        mem_ce_n, mem_cs2, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n;
    logic [19:0] mem_addr;
    logic [15:0] mem_dq_o;
    logic        mem_dq_oe;
    logic [15:0] mem_dq_i;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done_flag = 0;

    logic [15:0] model [1024];
    logic [15:0] refm  [1024];

    always #2.5 clk = ~clk;

    sram_ctl i_sram_ctl (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_lanes(req_lanes),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_ce_n(mem_ce_n), .mem_cs2(mem_cs2), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n),
        .mem_addr(mem_addr), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
        .mem_dq_i(mem_dq_i)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] d, input logic [1:0] m);
        logic [15:0] r = old;
        if (m[0]) r[7:0]  = d[7:0];
        if (m[1]) r[15:8] = d[15:8];
        return r;
    endfunction

    function automatic logic [15:0] lanes_of(input logic [15:0] w, input logic [1:0] m);
        return {m[1] ? w[15:8] : 8'h00, m[0] ? w[7:0] : 8'h00};
    endfunction

    // asynchronous memory model: drives only when selected, reading, and lane strobed
    wire sel   = !mem_ce_n && mem_cs2;
    wire rd_en = sel && !mem_oe_n && mem_we_n;
    wire wr_en = sel && !mem_we_n && !(mem_lb_n && mem_ub_n);
    assign mem_dq_i = {(rd_en && !mem_ub_n) ? model[mem_addr[9:0]][15:8] : 8'hA5,
                       (rd_en && !mem_lb_n) ? model[mem_addr[9:0]][7:0]  : 8'hA5};

    logic        pend = 0;
    logic [9:0]  p_a;
    logic [15:0] p_d;
    logic [1:0]  p_m;
    int we_run = 0, oe_run = 0, since_oe = 100, setup_run = 0;
    logic        prev_sel = 0;
    logic [19:0] prev_addr;

    always @(negedge clk) begin
        if (!rst) begin
            if (wr_en) begin
                pend <= 1; p_a <= mem_addr[9:0]; p_d <= mem_dq_o;
                p_m <= {!mem_ub_n, !mem_lb_n};
            end else if (pend) begin
                model[p_a] <= merge(model[p_a], p_d, p_m);
                pend <= 0;
            end
            if (mem_dq_oe && (rd_en || since_oe < 1))
                check(0, "R8 drive near read", 1, 0);
            if (sel && prev_sel && mem_addr != prev_addr)
                check(0, "R4 address moved while selected", mem_addr, prev_addr);
            prev_sel  <= sel;
            prev_addr <= mem_addr;
            since_oe  <= !mem_oe_n ? 0 : since_oe + 1;
            if (!mem_we_n) begin
                if (we_run == 0) check(setup_run >= 1, "R3 setup before pulse", setup_run, 1);
                we_run <= we_run + 1;
            end else if (we_run != 0) begin
                check(we_run == 7, "R3 pulse length", we_run, 7);
                we_run <= 0;
            end
            setup_run <= (sel && mem_we_n && mem_dq_oe) ? setup_run + 1 : 0;
            if (!mem_oe_n) oe_run <= oe_run + 1;
            else if (oe_run != 0) begin
                check(oe_run == 9, "R6 read phase length", oe_run, 9);
                oe_run <= 0;
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles == 150000 && !done_flag) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual %0d expected 0", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic op(input bit wr, input logic [19:0] a, input logic [15:0] d,
                      input logic [1:0] m, input bit chk_busy);
        int busy = 0;
        int pulses = 0;
        logic [15:0] got = '0;
        logic [15:0] exp;
        exp = lanes_of(refm[a[9:0]], m);
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_lanes = m;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 0;
        while (!req_ready) begin
            busy++;
            if (rsp_valid) begin pulses++; got = rsp_rdata; end
            @(negedge clk);
        end
        if (rsp_valid) pulses++;
        if (wr) begin
            refm[a[9:0]] = merge(refm[a[9:0]], d, m);
            check(pulses == 0, "R6 no response on write", pulses, 0);
            if (chk_busy) check(busy == 9, "R2 write busy", busy, 9);
        end else begin
            check(pulses == 1, "R6 one response pulse", pulses, 1);
            check(got == exp, "R7 read data lanes", got, exp);
            if (chk_busy) check(busy == 13, "R2 read busy", busy, 13);
        end
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) begin
            model[i] = 16'(i * 37 + 5);
            refm[i]  = 16'(i * 37 + 5);
        end
        repeat (4) @(negedge clk);
        // R1 reset state
        check(mem_ce_n && !mem_cs2 && mem_we_n && mem_oe_n && mem_lb_n && mem_ub_n && !mem_dq_oe,
              "R1 outputs in reset", {mem_ce_n, mem_cs2, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe},
              7'b1011110);
        rst = 0;
        @(negedge clk);
        check(req_ready == 1, "R1 ready after reset", req_ready, 1);
        check(rsp_valid == 0, "R1 no response after reset", rsp_valid, 0);

        // R2 R5 full-word write at top address then read back
        op(1, 20'hFFFFF, 16'h1234, 2'b11, 1);
        op(0, 20'hFFFFF, 16'h0, 2'b11, 1);
        // R5 single-lane writes
        op(1, 20'h00010, 16'hABCD, 2'b01, 1);
        check(model[16] == merge(16'(16*37+5), 16'hABCD, 2'b01), "R5 lower lane write",
              model[16], merge(16'(16*37+5), 16'hABCD, 2'b01));
        op(1, 20'h00010, 16'h5600, 2'b10, 1);
        op(1, 20'h00010, 16'hFFFF, 2'b00, 1);
        check(model[16] == refm[16], "R5 mask 00 leaves memory", model[16], refm[16]);
        // R7 partial reads
        op(0, 20'h00010, 16'h0, 2'b01, 1);
        op(0, 20'h00010, 16'h0, 2'b10, 1);
        op(0, 20'h00010, 16'h0, 2'b00, 1);
        op(0, 20'h00010, 16'h0, 2'b11, 1);

        // random mix, back to back (R2 R3 R4 R5 R6 R7 R8)
        void'($urandom(32'd1234));
        for (int k = 0; k < 300; k++) begin
            op($urandom_range(0, 1), 20'($urandom), 16'($urandom),
               2'($urandom_range(0, 3)), 1);
        end
        for (int i = 0; i < 1024; i++)
            if (model[i] != refm[i]) check(0, "R5 final memory image", model[i], refm[i]);
        check(1, "R5 final memory image scanned", 0, 0);

        done_flag = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule